// File: doc/BRIEF.md
# Serial Converter Write Sequencer

This block sits on the host side of a three-wire serial link to a quad 12-bit voltage-output converter. A client hands it a request with a 2-bit channel number and a 12-bit code. The block builds the 16-bit serial word, lowers the select line, clocks the word out MSB first, releases select, and then pulses the load line so the addressed converter channel takes the new code.

Every minimum interval on the link is a parameter counted in system-clock cycles and rounded up from the converter's nanosecond limits. These intervals are select-to-first-clock, data setup and hold, clock high and low, select release, load delay, load width and clear width. A request can also ask for a clear pulse instead of a write. Requests use a valid/ready handshake, and each finished operation raises a one-cycle done pulse. All parameters must be at least 1.

Top module: `dacw_ctrl`

## Requirements
- R1: After reset, and whenever idle, `sel_n`, `ld_n` and `clr_n` are 1, `sclk` is 0 and `req_ready` is 1.
- R2: A write shifts 16 bits MSB first, each taken at a rising edge of `sclk`: `req_chan[1]`, `req_chan[0]`, then two zero bits, then `req_code[11]` down to `req_code[0]`.
- R3: `sdata` changes only in cycles where `sclk` is 0. It is stable in the cycle where `sclk` rises and in every cycle where `sclk` is high.
- R4: Each `sclk` high phase lasts exactly max(T_HIGH, T_HOLD) cycles. Each low phase between two pulses lasts exactly max(T_LOW, T_SETUP) cycles.
- R5: A write produces exactly 16 rising edges of `sclk`. The first one comes exactly max(T_SELCLK, T_SETUP) cycles after `sel_n` falls.
- R6: `sel_n` rises exactly T_DESEL cycles after the last falling edge of `sclk`. `ld_n` falls exactly T_LDDLY cycles after `sel_n` rises, and it stays low for exactly T_LDW cycles.
- R7: `done` is a one-cycle pulse. For a write it rises exactly T_LDPOST cycles after `ld_n` rises. `req_ready` stays 0 from acceptance until the cycle in which `done` is high.
- R8: A request presented while the block is busy is not taken until the running operation has finished. It is then sent intact, with its `sel_n` falling only after the previous `done`.
- R9: A request with `req_clear`=1 drives `clr_n` low for exactly T_CLRW cycles, with no activity on `sel_n`, `sclk` or `ld_n`. `done` rises in the cycle where `clr_n` returns high.
- R10: `ld_n` is never low while `sel_n` is low, and `sclk` is never high while `sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; the request is taken at the edge where both valid and ready are high |
| req_clear | input | 1 | 1 = clear pulse, 0 = channel write |
| req_chan | input | 2 | Target converter channel |
| req_code | input | 12 | Code to write |
| sel_n | output | 1 | Serial select, active low |
| sclk | output | 1 | Serial clock; the converter samples on its rising edge |
| sdata | output | 1 | Serial data |
| ld_n | output | 1 | Load strobe, active low |
| clr_n | output | 1 | Clear strobe, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a request that arrives while a write is still running. It must wait through the load pulse and the trailing delay and then start cleanly just after `done`. The stimulus offers a second request straight after the first one is accepted and holds it. The bench then checks that ready stays low, that the second select falls only after the first `done`, and that both words come out intact. A clear placed between writes shows that the clear path leaves the link pins untouched and that the next write starts from a clean idle state.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    localparam int CHAN_W = 2;
    localparam int CODE_W = 12;
    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SEL,
        S_HIGH,
        S_LOW,
        S_DESEL,
        S_LDDLY,
        S_LDW,
        S_LDPOST,
        S_CLR
    } seq_state_e;

    typedef struct packed {
        logic              clear;
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } dacw_req_t;

    typedef struct packed {
        logic sel_n;
        logic sclk;
        logic ld_n;
        logic clr_n;
    } dacw_pins_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic [CHAN_W-1:0] ch,
                                                    input logic [CODE_W-1:0] cd);
        return {ch, 2'b00, cd};
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/dacw_timer.sv
module dacw_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out,
    output logic              last
);

    localparam int IDX_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sreg;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= word;
            idx  <= IDX_W'(WORD_W - 1);
        end else if (shift) begin
            sreg <= {sreg[WORD_W-2:0], 1'b0};
            idx  <= idx - 1'b1;
        end
    end

    assign bit_out = sreg[WORD_W-1];
    assign last    = (idx == '0);

    // R5: the sequencer never asks for a shift beyond the last bit
    p_shift_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        shift |-> (idx != '0));

endmodule

// File: rtl/dacw_seq.sv
module dacw_seq
    import dacw_pkg::*;
#(
    parameter int T_SETUP  = 4,
    parameter int T_HOLD   = 7,
    parameter int T_HIGH   = 12,
    parameter int T_LOW    = 15,
    parameter int T_SELCLK = 12,
    parameter int T_DESEL  = 1,
    parameter int T_LDDLY  = 17,
    parameter int T_LDW    = 10,
    parameter int T_LDPOST = 2,
    parameter int T_CLRW   = 19,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_clear,
    input  logic             last,
    input  logic             tzero,
    output logic             req_ready,
    output logic             tload,
    output logic [CNT_W-1:0] tload_val,
    output logic             sh_load,
    output logic             sh_shift,
    output dacw_pins_t       pins,
    output logic             done
);

    localparam int HI_CYC = at_least_one(max2(T_HIGH, T_HOLD));
    localparam int LO_CYC = at_least_one(max2(T_LOW, T_SETUP));
    localparam int SC_CYC = at_least_one(max2(T_SELCLK, T_SETUP));

    seq_state_e state, nxt;
    logic       accept;

    function automatic int dur(input seq_state_e s);
        case (s)
            S_SEL:    return SC_CYC;
            S_HIGH:   return HI_CYC;
            S_LOW:    return LO_CYC;
            S_DESEL:  return at_least_one(T_DESEL);
            S_LDDLY:  return at_least_one(T_LDDLY);
            S_LDW:    return at_least_one(T_LDW);
            S_LDPOST: return at_least_one(T_LDPOST);
            S_CLR:    return at_least_one(T_CLRW);
            default:  return 1;
        endcase
    endfunction

    function automatic dacw_pins_t pins_of(input seq_state_e s);
        dacw_pins_t p;
        p.sel_n = !(s inside {S_SEL, S_HIGH, S_LOW, S_DESEL});
        p.sclk  = (s == S_HIGH);
        p.ld_n  = (s != S_LDW);
        p.clr_n = (s != S_CLR);
        return p;
    endfunction

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:   if (accept) nxt = req_clear ? S_CLR : S_SEL;
            S_SEL:    if (tzero) nxt = S_HIGH;
            S_HIGH:   if (tzero) nxt = last ? S_DESEL : S_LOW;
            S_LOW:    if (tzero) nxt = S_HIGH;
            S_DESEL:  if (tzero) nxt = S_LDDLY;
            S_LDDLY:  if (tzero) nxt = S_LDW;
            S_LDW:    if (tzero) nxt = S_LDPOST;
            S_LDPOST: if (tzero) nxt = S_IDLE;
            S_CLR:    if (tzero) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    assign tload     = (nxt != state);
    assign tload_val = CNT_W'(dur(nxt) - 1);
    assign sh_load   = accept && !req_clear;
    assign sh_shift  = (state == S_HIGH) && tzero && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            pins  <= pins_of(S_IDLE);
            done  <= 1'b0;
        end else begin
            state <= nxt;
            pins  <= pins_of(nxt);
            done  <= (nxt == S_IDLE) && (state != S_IDLE);
        end
    end

    // R7: done never lasts more than one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: no acceptance while a previous operation is in flight
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !tzero) |=> !req_ready || $past(state == S_IDLE));

endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
    import dacw_pkg::*;
#(
    parameter int T_SETUP  = 4,
    parameter int T_HOLD   = 7,
    parameter int T_HIGH   = 12,
    parameter int T_LOW    = 15,
    parameter int T_SELCLK = 12,
    parameter int T_DESEL  = 1,
    parameter int T_LDDLY  = 17,
    parameter int T_LDW    = 10,
    parameter int T_LDPOST = 2,
    parameter int T_CLRW   = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_clear,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [CODE_W-1:0] req_code,
    output logic              sel_n,
    output logic              sclk,
    output logic              sdata,
    output logic              ld_n,
    output logic              clr_n,
    output logic              done
);

    localparam int T_SUM = T_SETUP + T_HOLD + T_HIGH + T_LOW + T_SELCLK
                         + T_DESEL + T_LDDLY + T_LDW + T_LDPOST + T_CLRW;
    localparam int CNT_W = $clog2(T_SUM + 2);

    dacw_req_t         req_s;
    dacw_pins_t        pins;
    logic              tload, tzero, sh_load, sh_shift, last;
    logic [CNT_W-1:0]  tload_val;

    assign req_s = '{clear: req_clear, chan: req_chan, code: req_code};

    dacw_seq #(
        .T_SETUP (T_SETUP),  .T_HOLD  (T_HOLD),   .T_HIGH (T_HIGH),
        .T_LOW   (T_LOW),    .T_SELCLK(T_SELCLK), .T_DESEL(T_DESEL),
        .T_LDDLY (T_LDDLY),  .T_LDW   (T_LDW),    .T_LDPOST(T_LDPOST),
        .T_CLRW  (T_CLRW),   .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_clear (req_s.clear),
        .last      (last),
        .tzero     (tzero),
        .req_ready (req_ready),
        .tload     (tload),
        .tload_val (tload_val),
        .sh_load   (sh_load),
        .sh_shift  (sh_shift),
        .pins      (pins),
        .done      (done)
    );

    dacw_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .load_val (tload_val),
        .zero     (tzero)
    );

    dacw_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (sh_load),
        .shift   (sh_shift),
        .word    (pack_word(req_s.chan, req_s.code)),
        .bit_out (sdata),
        .last    (last)
    );

    assign sel_n = pins.sel_n;
    assign sclk  = pins.sclk;
    assign ld_n  = pins.ld_n;
    assign clr_n = pins.clr_n;

    // R3: data holds while the serial clock is high, including its rising cycle
    p_data_stable_r3: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdata));

    // R10: the load strobe is kept apart from the select window
    p_ld_outside_sel_r10: assert property (@(posedge clk) disable iff (rst)
        !sel_n |-> ld_n);

    // R10: the serial clock only toggles inside the select window
    p_clk_inside_sel_r10: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !sel_n);

    // R9: a clear pulse leaves the serial link and load idle
    p_clr_isolated_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (sel_n && ld_n && !sclk));

    // R1: an idle block shows the quiet pin levels
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !done) |-> (sel_n && ld_n && clr_n && !sclk));

    // R5: the first clock rise is preceded by an already asserted select
    p_sel_before_clk_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $past(!sel_n));

endmodule

// File: tb/dacw_ctrl_bench.sv
`timescale 1ns/1ps
module dacw_ctrl_bench;

    localparam int P_SETUP  = 4;
    localparam int P_HOLD   = 7;
    localparam int P_HIGH   = 12;
    localparam int P_LOW    = 15;
    localparam int P_SELCLK = 12;
    localparam int P_DESEL  = 1;
    localparam int P_LDDLY  = 17;
    localparam int P_LDW    = 10;
    localparam int P_LDPOST = 2;
    localparam int P_CLRW   = 19;

    localparam int E_HI = (P_HIGH > P_HOLD) ? P_HIGH : P_HOLD;
    localparam int E_LO = (P_LOW > P_SETUP) ? P_LOW : P_SETUP;
    localparam int E_SC = (P_SELCLK > P_SETUP) ? P_SELCLK : P_SETUP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_clear = 1'b0;
    logic [1:0]  req_chan = '0;
    logic [11:0] req_code = '0;
    logic        req_ready, sel_n, sclk, sdata, ld_n, clr_n, done;

    always #4 clk = ~clk;

    dacw_ctrl #(
        .T_SETUP(P_SETUP), .T_HOLD(P_HOLD), .T_HIGH(P_HIGH), .T_LOW(P_LOW),
        .T_SELCLK(P_SELCLK), .T_DESEL(P_DESEL), .T_LDDLY(P_LDDLY),
        .T_LDW(P_LDW), .T_LDPOST(P_LDPOST), .T_CLRW(P_CLRW)
    ) u_dacw_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_clear(req_clear), .req_chan(req_chan), .req_code(req_code),
        .sel_n(sel_n), .sclk(sclk), .sdata(sdata), .ld_n(ld_n),
        .clr_n(clr_n), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor state, per write index
    int wi = -1;
    int sel_fall[16], sel_rise[16], first_rise[16], last_fall[16];
    int ld_fall[16], ld_rise[16], done_t[16], nrise[16], hi_bad[16], lo_bad[16];
    logic [15:0] word_cap[16];
    int rise_t = 0, n_done = 0, last_done = 0, n_ldf = 0;
    int clr_fall = 0, clr_rise = 0, data_bad = 0, ovl = 0, wide_done = 0;
    logic p_sel = 1, p_sclk = 0, p_ld = 1, p_clr = 1, p_sdata = 0, p_done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_sel && !sel_n) begin
                wi = wi + 1;
                sel_fall[wi] = cyc; nrise[wi] = 0; word_cap[wi] = '0;
                hi_bad[wi] = 0; lo_bad[wi] = 0;
            end
            if (!p_sclk && sclk && wi >= 0) begin
                if (nrise[wi] == 0) first_rise[wi] = cyc;
                else if (cyc - last_fall[wi] != E_LO) lo_bad[wi] = lo_bad[wi] + 1;
                nrise[wi] = nrise[wi] + 1;
                word_cap[wi] = {word_cap[wi][14:0], sdata};
                rise_t = cyc;
            end
            if (p_sclk && !sclk && wi >= 0) begin
                if (cyc - rise_t != E_HI) hi_bad[wi] = hi_bad[wi] + 1;
                last_fall[wi] = cyc;
            end
            if (sclk && sdata != p_sdata) data_bad = data_bad + 1;
            if (!p_sel && sel_n && wi >= 0) sel_rise[wi] = cyc;
            if (p_ld && !ld_n) begin n_ldf = n_ldf + 1; if (wi >= 0) ld_fall[wi] = cyc; end
            if (!p_ld && ld_n && wi >= 0) ld_rise[wi] = cyc;
            if (p_clr && !clr_n) clr_fall = cyc;
            if (!p_clr && clr_n) clr_rise = cyc;
            if ((!sel_n && !ld_n) || (sel_n && sclk)) ovl = ovl + 1;
            if (done) begin
                n_done = n_done + 1; last_done = cyc;
                if (wi >= 0) done_t[wi] = cyc;
                if (p_done) wide_done = wide_done + 1;
            end
        end
        p_sel = sel_n; p_sclk = sclk; p_ld = ld_n; p_clr = clr_n;
        p_sdata = sdata; p_done = done;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary_and_end();
        end
    end

    // offer a request and return one negedge after it was taken
    task automatic offer(input bit clr, input logic [1:0] ch, input logic [11:0] cd);
        int guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_clear = clr; req_chan = ch; req_code = cd;
        while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done_count(input int target);
        int guard = 0;
        while (n_done < target && guard < 5000) begin @(posedge clk); guard++; end
        chk(n_done >= target, "R7 done arrives", n_done, target);
        @(posedge clk);
    endtask

    task automatic check_write(input int idx, input logic [1:0] ch, input logic [11:0] cd);
        logic [15:0] exp_w;
        exp_w = {ch, 2'b00, cd};
        chk(word_cap[idx] == exp_w, "R2 serial word", int'(word_cap[idx]), int'(exp_w));
        chk(nrise[idx] == 16, "R5 rising edge count", nrise[idx], 16);
        chk(first_rise[idx] - sel_fall[idx] == E_SC, "R5 select to first clock",
            first_rise[idx] - sel_fall[idx], E_SC);
        chk(hi_bad[idx] == 0, "R4 high phase length", hi_bad[idx], 0);
        chk(lo_bad[idx] == 0, "R4 low phase length", lo_bad[idx], 0);
        chk(sel_rise[idx] - last_fall[idx] == P_DESEL, "R6 select release",
            sel_rise[idx] - last_fall[idx], P_DESEL);
        chk(ld_fall[idx] - sel_rise[idx] == P_LDDLY, "R6 load delay",
            ld_fall[idx] - sel_rise[idx], P_LDDLY);
        chk(ld_rise[idx] - ld_fall[idx] == P_LDW, "R6 load width",
            ld_rise[idx] - ld_fall[idx], P_LDW);
        chk(done_t[idx] - ld_rise[idx] == P_LDPOST, "R7 done after load",
            done_t[idx] - ld_rise[idx], P_LDPOST);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sel_n == 1 && ld_n == 1 && clr_n == 1, "R1 idle strobes high",
            {sel_n, ld_n, clr_n}, 7);
        chk(sclk == 0, "R1 idle clock low", sclk, 0);
        chk(req_ready == 1 && done == 0, "R1 ready idle", {req_ready, done}, 2);
    endtask

    task automatic t_single(input logic [1:0] ch, input logic [11:0] cd);
        int base = n_done;
        int idx = wi + 1;
        offer(1'b0, ch, cd);
        chk(req_ready == 0, "R7 busy after accept", req_ready, 0);
        wait_done_count(base + 1);
        check_write(idx, ch, cd);
    endtask

    task automatic t_back_to_back();
        int base = n_done;
        int idx = wi + 1;
        int guard = 0;
        offer(1'b0, 2'd1, 12'h5A3);
        req_valid = 1'b1; req_clear = 1'b0; req_chan = 2'd2; req_code = 12'hC3C;
        chk(req_ready == 0, "R8 second request held off", req_ready, 0);
        while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
        chk(done == 1, "R7 ready returns with done", done, 1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_done_count(base + 2);
        check_write(idx, 2'd1, 12'h5A3);
        check_write(idx + 1, 2'd2, 12'hC3C);
        chk(sel_fall[idx + 1] > done_t[idx], "R8 next select after done",
            sel_fall[idx + 1], done_t[idx] + 1);
    endtask

    task automatic t_clear();
        int base = n_done;
        int w0 = wi;
        int l0 = n_ldf;
        offer(1'b1, 2'd3, 12'hFFF);
        wait_done_count(base + 1);
        chk(clr_rise - clr_fall == P_CLRW, "R9 clear width", clr_rise - clr_fall, P_CLRW);
        chk(last_done == clr_rise, "R9 done with clear release", last_done, clr_rise);
        chk(wi == w0 && n_ldf == l0, "R9 no link activity", wi - w0 + n_ldf - l0, 0);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin
            sel_fall[k] = 0; sel_rise[k] = 0; first_rise[k] = 0; last_fall[k] = 0;
            ld_fall[k] = 0; ld_rise[k] = 0; done_t[k] = 0; nrise[k] = 0;
            hi_bad[k] = 0; lo_bad[k] = 0; word_cap[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single(2'd0, 12'hABC);
        t_single(2'd3, 12'h000);
        t_single(2'd2, 12'hFFF);
        t_back_to_back();
        t_clear();
        t_single(2'd1, 12'h801);
        t_reset();
        chk(data_bad == 0, "R3 data stable while clock high", data_bad, 0);
        chk(ovl == 0, "R10 strobe separation", ovl, 0);
        chk(wide_done == 0, "R7 done single cycle", wide_done, 0);
        summary_and_end();
    end

endmodule